// File: doc/BRIEF.md
# Cascadable 32-Source Interrupt Controller

This block gathers 32 interrupt request lines and reduces them to two outputs: a normal interrupt and a critical interrupt. Software reaches a small bank of 32-bit registers through a single-cycle port made of an address, a write enable, write data and combinational read data. Each source is set up on its own. Software chooses whether it is sensed by edge or by level, which edge or level is active, and whether it is enabled. It also chooses which of the two outputs the source is routed to.

Pending events are recorded in a status word. Software can read that word raw, or read it masked by the enable word. Pending bits are cleared by writing ones. Both outputs are plain registered signals. One instance can therefore drive a request line of another instance, and controllers chained this way form a tree.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: While reset is asserted, every register offset reads zero and both outputs are low.
- R2: Request line n is reported in bit position 31-n of every per-source word, so line 0 lands in bit 31.
- R3: With its trigger bit at 0, a source is level sensed. Its status bit is set on every cycle in which the synchronized line equals its polarity bit (1 = high active, 0 = low active).
- R4: With its trigger bit at 1, a source is edge sensed. A change of the synchronized line toward its polarity value sets the status bit (polarity 1 = rising edge, polarity 0 = falling edge). A change in the other direction does not set it. The bit then stays set after the line returns.
- R5: Writing offset 0x0 clears each status bit whose write-data bit is 1. Bits written with 0 are unchanged, and status bits are never cleared by any other means.
- R6: A write-one clear of a level-sensed source whose line is still active has no lasting effect, even when the source is disabled.
- R7: Offset 0x6 reads the status word ANDed with the enable word.
- R8: The normal output is, one cycle later, the OR of the enabled pending bits whose route bit is 0. The critical output is the same OR over those whose route bit is 1. Both outputs are low when no enabled bit is pending.
- R9: When a set event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Offsets 0x7 and 0x8 always read zero and ignore writes. Every other offset without a register also reads zero.
- R11: Offsets 0x2 (enable), 0x3 (route to critical), 0x4 (polarity) and 0x5 (trigger) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Request lines, line n at index n |
| regAddr | input | ADDR_W (4) | Register word offset |
| regWe | input | 1 | Write strobe for the addressed register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the addressed register, combinational |
| irqNormal | output | 1 | Registered normal interrupt request |
| irqCrit | output | 1 | Registered critical interrupt request |

## Verification
The assertions assume that the register address is stable and defined whenever it is sampled. The bench therefore drives the address, write data and request lines only on falling clock edges and holds each one for at least a full cycle. The assertions also assume that request lines start at their inactive level once the set-up is written. The bench raises every line before reset and flushes the status word after configuration, so any transient caused by the synchronizers' reset value is gone before a property about the status word is relied on.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC = 32;
  localparam int OFF_STATUS = 0;
  localparam int OFF_ENABLE = 2;
  localparam int OFF_CRIT   = 3;
  localparam int OFF_POL    = 4;
  localparam int OFF_TRIG   = 5;
  localparam int OFF_MASKED = 6;

  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrCrit;
    logic wrPol;
    logic wrTrig;
  } regStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [NUM_SRC-1:0] statusQ,
  input  logic [NUM_SRC-1:0] enableQ,
  input  logic [NUM_SRC-1:0] critQ,
  input  logic [NUM_SRC-1:0] polQ,
  input  logic [NUM_SRC-1:0] trigQ,
  output regStrobe_t         strobes,
  output logic [NUM_SRC-1:0] rdData
);
  // Write decode: one strobe per writable register.
  always_comb begin
    strobes          = '0;
    strobes.wrStatus = regWe && (regAddr == ADDR_W'(OFF_STATUS));
    strobes.wrEnable = regWe && (regAddr == ADDR_W'(OFF_ENABLE));
    strobes.wrCrit   = regWe && (regAddr == ADDR_W'(OFF_CRIT));
    strobes.wrPol    = regWe && (regAddr == ADDR_W'(OFF_POL));
    strobes.wrTrig   = regWe && (regAddr == ADDR_W'(OFF_TRIG));
  end

  // Read mux: the vector offsets and every unmapped offset fall to zero.
  always_comb begin
    if (regAddr == ADDR_W'(OFF_STATUS))      rdData = statusQ;
    else if (regAddr == ADDR_W'(OFF_ENABLE)) rdData = enableQ;
    else if (regAddr == ADDR_W'(OFF_CRIT))   rdData = critQ;
    else if (regAddr == ADDR_W'(OFF_POL))    rdData = polQ;
    else if (regAddr == ADDR_W'(OFF_TRIG))   rdData = trigQ;
    else if (regAddr == ADDR_W'(OFF_MASKED)) rdData = statusQ & enableQ;
    else                                     rdData = '0;
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] wrData,
  input  regStrobe_t         strobes,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [NUM_SRC-1:0] critQ,
  output logic [NUM_SRC-1:0] polQ,
  output logic [NUM_SRC-1:0] trigQ,
  output logic               irqNormal,
  output logic               irqCrit
);
  localparam int LAST = SYNC_STAGES - 1;

  // Line n is kept in bit 31-n throughout.
  logic [NUM_SRC-1:0] lineBits;
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
    assign lineBits[NUM_SRC-1-n] = srcIn[n];
  end

  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] syncQ;
  logic [NUM_SRC-1:0] prevQ, curBits, levelHit, edgeHit, setEv, clrMask, statusD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= lineBits;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign curBits  = syncQ[LAST];
  assign levelHit = ~(curBits ^ polQ);
  assign edgeHit  = (curBits ^ prevQ) & levelHit;
  assign setEv    = (trigQ & edgeHit) | (~trigQ & levelHit);
  assign clrMask  = strobes.wrStatus ? wrData : '0;
  assign statusD  = setEv | (statusQ & ~clrMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ   <= '0;
      enableQ   <= '0;
      critQ     <= '0;
      polQ      <= '0;
      trigQ     <= '0;
      irqNormal <= 1'b0;
      irqCrit   <= 1'b0;
    end else begin
      statusQ <= statusD;
      if (strobes.wrEnable) enableQ <= wrData;
      if (strobes.wrCrit)   critQ   <= wrData;
      if (strobes.wrPol)    polQ    <= wrData;
      if (strobes.wrTrig)   trigQ   <= wrData;
      irqNormal <= |(statusQ & enableQ & ~critQ);
      irqCrit   <= |(statusQ & enableQ & critQ);
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [NUM_SRC-1:0] regWdata,
  output logic [NUM_SRC-1:0] regRdata,
  output logic               irqNormal,
  output logic               irqCrit
);
  regStrobe_t strobes;
  logic [NUM_SRC-1:0] statusQ, enableQ, critQ, polQ, trigQ;

  irqc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr), .regWe(regWe),
    .statusQ(statusQ), .enableQ(enableQ), .critQ(critQ), .polQ(polQ), .trigQ(trigQ),
    .strobes(strobes), .rdData(regRdata)
  );

  irqc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .wrData(regWdata), .strobes(strobes),
    .statusQ(statusQ), .enableQ(enableQ), .critQ(critQ), .polQ(polQ), .trigQ(trigQ),
    .irqNormal(irqNormal), .irqCrit(irqCrit)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWe,
  input logic [NUM_SRC-1:0] regRdata,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] enableQ,
  input logic               irqNormal,
  input logic               irqCrit
);
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (statusQ == '0 && enableQ == '0 && !irqNormal && !irqCrit));

  p_masked_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == ADDR_W'(OFF_MASKED)) |-> (regRdata == (statusQ & enableQ)));

  p_vector_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr >= ADDR_W'(7)) |-> (regRdata == '0));

  p_no_stray_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWe && regAddr == ADDR_W'(OFF_STATUS)) |=> (($past(statusQ) & ~statusQ) == '0));

  p_quiet_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((statusQ & enableQ) == '0) |=> (!irqNormal && !irqCrit));
endmodule

bind cascade_irq_ctrl irqc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWe(regWe), .regRdata(regRdata),
  .statusQ(statusQ), .enableQ(enableQ), .irqNormal(irqNormal), .irqCrit(irqCrit)
);

// File: tb/cascade_irq_ctrl_bench.sv
module cascade_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expect_v;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{4'h2, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    '{4'h3, 32'h1234_5678, 32'h1234_5678},
    '{4'h4, 32'h0F0F_0000, 32'h0F0F_0000},
    '{4'h5, 32'hFFFF_0000, 32'hFFFF_0000},
    '{4'h7, 32'hFFFF_FFFF, 32'h0000_0000},
    '{4'h8, 32'hDEAD_BEEF, 32'h0000_0000},
    '{4'h9, 32'h1111_1111, 32'h0000_0000},
    '{4'h2, 32'h0000_0000, 32'h0000_0000},
    '{4'h3, 32'h0000_0000, 32'h0000_0000},
    '{4'h4, 32'h0000_0000, 32'h0000_0000},
    '{4'h5, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] srcIn = '1;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqNormal, irqCrit;
  int errors = 0;
  int checks = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_ctrl u_cascade_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .irqNormal(irqNormal), .irqCrit(irqCrit)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 / R10: everything reads zero while reset is held
    waitc(3);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), rv);
      check(rv, 32'h0, "R1 reset read");
    end
    check({31'h0, irqNormal | irqCrit}, 32'h0, "R1 outputs in reset");
    @(negedge clk) rst_n = 1'b1;
    waitc(4);

    // R11 / R10: register table walk
    foreach (TBL[i]) begin
      wr(TBL[i].addr, TBL[i].wdata);
      rd(TBL[i].addr, rv);
      check(rv, TBL[i].expect_v, "R11/R10 table readback");
    end

    // flush transient status (R5)
    wr(4'h0, 32'hFFFF_FFFF);
    waitc(2);
    rd(4'h0, rv);
    check(rv, 32'h0, "R5 clear all");

    // R2 / R3 / R6: line 0 held low, active-low level, disabled
    @(negedge clk) srcIn[0] = 1'b0;
    waitc(5);
    rd(4'h0, rv);
    check(rv, 32'h8000_0000, "R2/R3 line0 in bit31");
    check({30'h0, irqNormal, irqCrit}, 32'h0, "R8 disabled source quiet");
    wr(4'h0, 32'h8000_0000);
    rd(4'h0, rv);
    check(rv, 32'h8000_0000, "R6 level clear ignored while active");
    @(negedge clk) srcIn[0] = 1'b1;
    waitc(4);
    wr(4'h0, 32'h8000_0000);
    rd(4'h0, rv);
    check(rv, 32'h0, "R5 clear after release");

    // R3 / R7 / R8: line 5 (bit 26) active-high level, enabled, routing
    wr(4'h4, 32'h0400_0000);
    wr(4'h2, 32'h0400_0000);
    waitc(3);
    rd(4'h6, rv);
    check(rv, 32'h0400_0000, "R7 masked status");
    check({30'h0, irqNormal, irqCrit}, 32'h2, "R8 normal route");
    wr(4'h3, 32'h0400_0000);
    waitc(2);
    check({30'h0, irqNormal, irqCrit}, 32'h1, "R8 critical route");
    wr(4'h4, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h2, 32'h0);
    wr(4'h3, 32'h0);
    waitc(2);
    check({30'h0, irqNormal, irqCrit}, 32'h0, "R8 outputs drop");
    rd(4'h0, rv);
    check(rv, 32'h0, "R3 inactive level stays clear");

    // R4: line 10 (bit 21) rising edge
    wr(4'h5, 32'h0020_0000);
    wr(4'h4, 32'h0020_0000);
    @(negedge clk) srcIn[10] = 1'b0;
    waitc(5);
    rd(4'h0, rv);
    check(rv, 32'h0, "R4 wrong-direction edge ignored");
    @(negedge clk) srcIn[10] = 1'b1;
    waitc(5);
    rd(4'h0, rv);
    check(rv, 32'h0020_0000, "R4 rising edge sets");
    @(negedge clk) srcIn[10] = 1'b0;
    waitc(5);
    rd(4'h0, rv);
    check(rv, 32'h0020_0000, "R4 edge bit sticky");
    wr(4'h0, 32'h0);
    rd(4'h0, rv);
    check(rv, 32'h0020_0000, "R5 zero write keeps bit");
    wr(4'h0, 32'h0020_0000);
    rd(4'h0, rv);
    check(rv, 32'h0, "R5 one write clears edge bit");

    // R9: rising edge and clear land on the same edge
    @(negedge clk) srcIn[10] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    regAddr = 4'h0; regWdata = 32'h0020_0000; regWe = 1'b1;
    @(negedge clk) regWe = 1'b0;
    rd(4'h0, rv);
    check(rv, 32'h0020_0000, "R9 set wins over clear");
    wr(4'h0, 32'h0020_0000);

    // R4: falling edge with polarity 0
    wr(4'h4, 32'h0);
    waitc(2);
    rd(4'h0, rv);
    check(rv, 32'h0, "R4 no set on polarity change");
    @(negedge clk) srcIn[10] = 1'b0;
    waitc(5);
    rd(4'h0, rv);
    check(rv, 32'h0020_0000, "R4 falling edge sets");
    @(negedge clk) srcIn[10] = 1'b1;
    wr(4'h0, 32'h0020_0000);
    waitc(4);
    rd(4'h0, rv);
    check(rv, 32'h0, "R4 rising ignored with polarity 0");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule